// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of an asynchronous word-wide NOR flash, written as a clocked model. Each write cycle reaches it as one clock of `wr_en_i`, with a word address and a data word. The block tracks the multi-write unlock sequences and moves between four modes: read-array, device-ID query, CFI query, and busy while a program or erase runs. When a program, chip erase, sector erase or block erase sequence completes, it pulses `op_start_o` for one cycle. With that pulse it presents the operation kind, the target address and the data to write, and it then holds busy until the array controller raises `op_done_i`.

Only the low byte of a command write is decoded. Both unlock addresses are parameters. The block adds no back-pressure: the write strobe is a plain control pin, and a write that arrives while busy is dropped. The read path uses `mode_o` and the one-hot `rd_sel_o` to pick between array data and the ID or CFI tables, which live outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 0 (read-array), `rd_sel_o` is 0 and `op_start_o` is low. Mode encoding: 0 read-array, 1 ID, 2 CFI, 3 busy.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any address/data write give one `op_start_o` pulse with kind 0 (program), that address and that full data word. The pulse comes in the cycle after the last write.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h give a start with kind 1 (chip erase), address 0 and data FFFFh. A 10h confirm at any other address starts nothing.
- R4: The same five writes followed by 30h at any address give kind 2 (sector erase). Followed by 50h, they give kind 3 (block erase). Either carries the sixth write's address and data FFFFh.
- R5: The writes AAh@555h, 55h@2AAh, 90h@555h set mode 1 with `rd_sel_o`=01b. With 98h as the third write, they set mode 2 with `rd_sel_o`=10b. In read-array and busy, `rd_sel_o` is 00b.
- R6: In ID or CFI mode, a single write with low byte F0h at any address returns to mode 0. So does the sequence AAh@555h, 55h@2AAh followed by a third write. Any other single write leaves the mode unchanged.
- R7: The upper data byte of a command write has no effect on decoding.
- R8: A write that does not match the next expected write of a sequence drops the sequence. The block then returns to read-array without a start, and a following write does not continue the dropped sequence.
- R9: From a start until `op_done_i`, `mode_o` is 3 and every write is ignored: no start and no mode change. After `op_done_i`, the mode is 0.
- R10: `hw_rst_i` returns the block to mode 0 on the next cycle, from any state, busy included, and it discards a partial sequence.
- R11: `op_start_o` is never high for two cycles in a row, and whenever it is high, `mode_o` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_rst_i | input | 1 | Synchronous return to read-array |
| wr_en_i | input | 1 | One write cycle this clock |
| wr_addr_i | input | ADDR_W (20) | Word address of the write |
| wr_data_i | input | DATA_W (16) | Data of the write |
| op_done_i | input | 1 | Array finished the running operation |
| mode_o | output | 2 | 0 read-array, 1 ID, 2 CFI, 3 busy |
| rd_sel_o | output | 2 | Read source: bit0 ID table, bit1 CFI table |
| op_start_o | output | 1 | One-cycle operation launch |
| op_kind_o | output | 2 | 0 program, 1 chip, 2 sector, 3 block erase |
| op_addr_o | output | ADDR_W (20) | Target address of the launch |
| op_data_o | output | DATA_W (16) | Data to program, FFFFh for erase |

## Verification
The assertions assume that `op_done_i` is raised only while the block is busy and lasts one cycle. They also assume that `hw_rst_i` is a whole-cycle pulse. The bench keeps to this: it raises done only after it has seen a start, and it drives every input on the falling edge. Around those rules, the bench sweeps all 256 low-byte values through the third and sixth writes, at both the unlock address and a foreign one. It changes the upper byte on each pass and compares the outcome with values it works out from the command codes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_CFI  = 2'd2,
    MODE_BUSY = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_CHIP  = 2'd1,
    OP_SECT  = 2'd2,
    OP_BLOCK = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PARM,
    ST_ER3,
    ST_ER4,
    ST_ER5,
    ST_ID,
    ST_ID_X1,
    ST_ID_X2,
    ST_CFI,
    ST_CFI_X1,
    ST_CFI_X2,
    ST_BUSY
  } state_e;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_BLOCK = 8'h50;
  localparam logic [7:0] CODE_ID    = 8'h90;
  localparam logic [7:0] CODE_CFI   = 8'h98;
  localparam logic [7:0] CODE_EXIT  = 8'hF0;

  typedef struct packed {
    logic       at_a;
    logic       key1;
    logic       key2;
    logic [7:0] code;
  } hit_t;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 20'h00555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 20'h002AA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        code_i,
  output hit_t              hit_o
);

  logic at_a, at_b;

  assign at_a = (addr_i == KEY_ADDR_A);
  assign at_b = (addr_i == KEY_ADDR_B);

  always_comb begin
    hit_o.at_a = at_a;
    hit_o.key1 = at_a && (code_i == CODE_KEY1);
    hit_o.key2 = at_b && (code_i == CODE_KEY2);
    hit_o.code = code_i;
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hw_rst_i,
  input  logic   wr_en_i,
  input  hit_t   hit_i,
  input  logic   done_i,
  output state_e state_o,
  output logic   launch_o,
  output op_e    launch_kind_o
);

  state_e st_q, st_d;

  always_comb begin
    st_d          = st_q;
    launch_o      = 1'b0;
    launch_kind_o = OP_PROG;
    if (hw_rst_i) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_BUSY) begin
      if (done_i) st_d = ST_IDLE;
    end else if (wr_en_i) begin
      unique case (st_q)
        ST_IDLE: st_d = hit_i.key1 ? ST_UNL1 : ST_IDLE;
        ST_UNL1: st_d = hit_i.key2 ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          st_d = ST_IDLE;
          if (hit_i.at_a) begin
            case (hit_i.code)
              CODE_PROG:  st_d = ST_PARM;
              CODE_ERASE: st_d = ST_ER3;
              CODE_ID:    st_d = ST_ID;
              CODE_CFI:   st_d = ST_CFI;
              default:    st_d = ST_IDLE;
            endcase
          end
        end
        ST_PARM: begin
          launch_o      = 1'b1;
          launch_kind_o = OP_PROG;
          st_d          = ST_BUSY;
        end
        ST_ER3: st_d = hit_i.key1 ? ST_ER4 : ST_IDLE;
        ST_ER4: st_d = hit_i.key2 ? ST_ER5 : ST_IDLE;
        ST_ER5: begin
          st_d = ST_IDLE;
          if (hit_i.code == CODE_CHIP && hit_i.at_a) begin
            launch_o      = 1'b1;
            launch_kind_o = OP_CHIP;
            st_d          = ST_BUSY;
          end else if (hit_i.code == CODE_SECT) begin
            launch_o      = 1'b1;
            launch_kind_o = OP_SECT;
            st_d          = ST_BUSY;
          end else if (hit_i.code == CODE_BLOCK) begin
            launch_o      = 1'b1;
            launch_kind_o = OP_BLOCK;
            st_d          = ST_BUSY;
          end
        end
        ST_ID: begin
          if (hit_i.code == CODE_EXIT) st_d = ST_IDLE;
          else if (hit_i.key1)         st_d = ST_ID_X1;
        end
        ST_ID_X1: st_d = hit_i.key2 ? ST_ID_X2 : ST_IDLE;
        ST_ID_X2: st_d = ST_IDLE;
        ST_CFI: begin
          if (hit_i.code == CODE_EXIT) st_d = ST_IDLE;
          else if (hit_i.key1)         st_d = ST_CFI_X1;
        end
        ST_CFI_X1: st_d = hit_i.key2 ? ST_CFI_X2 : ST_IDLE;
        ST_CFI_X2: st_d = ST_IDLE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R8
  key_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UNL1 && wr_en_i && !hit_i.key2 && !hw_rst_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  op_e               kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output op_e               kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [DATA_W-1:0] ERASED = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      kind_o  <= OP_PROG;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      start_o <= launch_i;
      if (launch_i) begin
        kind_o <= kind_i;
        addr_o <= (kind_i == OP_CHIP) ? '0 : addr_i;
        data_o <= (kind_i == OP_PROG) ? data_i : ERASED;
      end
    end
  end

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 20'h00555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 20'h002AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              op_done_i,
  output logic [1:0]        mode_o,
  output logic [1:0]        rd_sel_o,
  output logic              op_start_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);

  hit_t   hit;
  state_e state;
  logic   launch;
  op_e    launch_kind;
  op_e    kind_q;
  mode_e  mode;

  flash_cmd_classify #(
    .ADDR_W    (ADDR_W),
    .KEY_ADDR_A(KEY_ADDR_A),
    .KEY_ADDR_B(KEY_ADDR_B)
  ) u_classify (
    .addr_i(wr_addr_i),
    .code_i(wr_data_i[7:0]),
    .hit_o (hit)
  );

  flash_cmd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_rst_i     (hw_rst_i),
    .wr_en_i      (wr_en_i),
    .hit_i        (hit),
    .done_i       (op_done_i),
    .state_o      (state),
    .launch_o     (launch),
    .launch_kind_o(launch_kind)
  );

  flash_cmd_launch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch),
    .kind_i  (launch_kind),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .start_o (op_start_o),
    .kind_o  (kind_q),
    .addr_o  (op_addr_o),
    .data_o  (op_data_o)
  );

  always_comb begin
    unique case (state)
      ST_BUSY:                      mode = MODE_BUSY;
      ST_ID, ST_ID_X1, ST_ID_X2:    mode = MODE_ID;
      ST_CFI, ST_CFI_X1, ST_CFI_X2: mode = MODE_CFI;
      default:                      mode = MODE_READ;
    endcase
  end

  assign mode_o    = mode;
  assign rd_sel_o  = {mode == MODE_CFI, mode == MODE_ID};
  assign op_kind_o = kind_q;

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_BUSY && !op_done_i && !hw_rst_i) |=> (mode_o == MODE_BUSY && !op_start_o));

  // R10
  hwrst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst_i |=> (mode_o == MODE_READ && !op_start_o));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_o |-> (mode_o == MODE_BUSY));

  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o == MODE_BUSY) |-> op_start_o);

endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_rst = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          op_done = 1'b0;
  logic [1:0]    mode, rd_sel, op_kind;
  logic          op_start;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .hw_rst_i(hw_rst), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .op_done_i(op_done),
    .mode_o(mode), .rd_sel_o(rd_sel), .op_start_o(op_start),
    .op_kind_o(op_kind), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with results visible.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hwrst();
    hw_rst = 1'b1;
    @(negedge clk);
    hw_rst = 1'b0;
  endtask

  task automatic done();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic erase_prefix(input logic [7:0] up);
    wr(20'h00555, {up, 8'hAA});
    wr(20'h002AA, {up, 8'h55});
    wr(20'h00555, {up, 8'h80});
    wr(20'h00555, {up, 8'hAA});
    wr(20'h002AA, {up, 8'h55});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] tgt;
    bit exp_start;
    logic [1:0] exp_mode, exp_kind;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(rd_sel == 2'd0, "R1 rd_sel", rd_sel, 0);
    chk(op_start == 1'b0, "R1 start", op_start, 0);
    rst_n = 1'b1;
    idle(2);
    chk(mode == 2'd0 && !op_start, "R1 after release", mode, 0);

    // R5 R2 R7 R8: sweep every third-write code, upper byte varied
    for (int v = 0; v < 256; v++) begin
      wr(20'h00555, {v[7:0], 8'hAA});
      wr(20'h002AA, {~v[7:0], 8'h55});
      wr(20'h00555, {v[7:0], v[7:0]});
      exp_mode = (v == 8'h90) ? 2'd1 : (v == 8'h98) ? 2'd2 : 2'd0;
      chk(mode == exp_mode, "R5 third-write mode", mode, exp_mode);
      chk(rd_sel == ((exp_mode == 2'd1) ? 2'b01 : (exp_mode == 2'd2) ? 2'b10 : 2'b00),
          "R5 rd_sel", rd_sel, exp_mode);
      wr(20'h00123 + v[19:0], 16'hC000 | v[15:0]);
      exp_start = (v == 8'hA0);
      chk(op_start == exp_start, "R8 start only after program arm", op_start, exp_start);
      if (exp_start) begin
        chk(op_kind == 2'd0 && op_addr == 20'h00123 + 20'hA0 && op_data == 16'hC0A0,
            "R2 program fields", {op_kind, op_addr}, {2'd0, 20'h001C3});
        chk(mode == 2'd3, "R9 busy after program", mode, 3);
        @(negedge clk);
        chk(op_start == 1'b0, "R11 single pulse", op_start, 0);
        done();
        chk(mode == 2'd0, "R9 read after done", mode, 0);
      end
      hwrst();
    end

    // R3 R4: sweep sixth-write code at the unlock address and elsewhere
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        tgt = (p == 0) ? 20'h00555 : 20'h48000 + 20'(v);
        erase_prefix(8'(v + 7));
        wr(tgt, {8'(v * 3), v[7:0]});
        exp_start = (v == 8'h30) || (v == 8'h50) || (v == 8'h10 && p == 0);
        exp_kind  = (v == 8'h10) ? 2'd1 : (v == 8'h30) ? 2'd2 : 2'd3;
        chk(op_start == exp_start, "R3 R4 erase confirm start", op_start, exp_start);
        chk(mode == (exp_start ? 2'd3 : 2'd0), "R8 mode after sixth", mode, exp_start ? 3 : 0);
        if (exp_start) begin
          chk(op_kind == exp_kind, "R4 kind", op_kind, exp_kind);
          chk(op_addr == ((exp_kind == 2'd1) ? 20'h0 : tgt), "R3 R4 address", op_addr, tgt);
          chk(op_data == 16'hFFFF, "R3 erase data", op_data, 16'hFFFF);
          done();
        end
        hwrst();
      end
    end

    // R9: writes during busy are ignored
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00777, 16'h1234);
    chk(op_start, "R2 start", op_start, 1);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00888, 16'h5678);
    chk(!op_start && mode == 2'd3, "R9 write ignored while busy", {op_start, mode}, 3'b011);
    chk(op_addr == 20'h00777 && op_data == 16'h1234, "R9 fields held", op_data, 16'h1234);
    done();
    chk(mode == 2'd0, "R9 done", mode, 0);
    wr(20'h00888, 16'h5678);
    chk(!op_start, "R9 no stale arm", op_start, 0);

    // R10: hw reset from busy and mid-sequence
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00001, 16'h0001);
    hwrst();
    chk(mode == 2'd0, "R10 reset from busy", mode, 0);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055);
    hwrst();
    wr(20'h00555, 16'h00A0); wr(20'h00002, 16'h0002);
    chk(!op_start && mode == 2'd0, "R10 partial discarded", op_start, 0);

    // R8: abort then leftover writes do not resume
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0056);
    wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0); wr(20'h00003, 16'h0003);
    chk(!op_start && mode == 2'd0, "R8 abort", op_start, 0);

    // R6: ID mode ignores others, single F0 exits at any address
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0090);
    wr(20'h00100, 16'h1234);
    chk(mode == 2'd1, "R6 ID holds on other write", mode, 1);
    wr(20'h3ABCD, 16'hA5F0);
    chk(mode == 2'd0, "R6 single exit", mode, 0);
    // R6: CFI three-write exit
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0098);
    wr(20'h00555, 16'h00AA);
    chk(mode == 2'd2 && rd_sel == 2'b10, "R6 CFI holds mid exit", mode, 2);
    wr(20'h002AA, 16'h0055);
    chk(mode == 2'd2, "R6 CFI holds second exit", mode, 2);
    wr(20'h00555, 16'h00F0);
    chk(mode == 2'd0 && rd_sel == 2'b00, "R6 three-write exit", mode, 0);
    // R6 R8: broken exit sequence in ID mode aborts to read
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0090);
    wr(20'h00555, 16'h00AA); wr(20'h00100, 16'h0055);
    chk(mode == 2'd0, "R8 broken exit", mode, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule